// File: doc/BRIEF.md
# Serial CRC-16 Generator and Checker

This block computes a 16-bit cyclic redundancy check one bit per clock. The generator polynomial is the product of (x+1) and a degree-15 primitive factor, which multiplies out to x^16 + x^12 + x^5 + 1 (low-term mask 0x1021). A frame is opened with a start pulse that clears the register and latches the mode. Bits are then fed most-significant first, one per cycle while a valid strobe is high. A last flag travels with the final bit of the frame.

In generate mode the frame is a message d(x). After its last bit, the block plays the remainder of x^16·d(x) divided by g(x) out on a serial line, most-significant bit first. Appending those 16 bits below the message gives a systematic codeword. In check mode the frame is a whole received codeword. When it ends, the block raises an error flag if the remainder is not zero. A build parameter chooses the register structure. It can have an XOR between stages with a widely fanned-out feedback bit, or a single XOR tree feeding one shift chain. Both structures give the same remainder.

Top module: `crc16_serial`

## Requirements
- R1: During and straight after a synchronous reset, crc_bit_o, crc_valid_o, done_o and err_o are all 0.
- R2: In generate mode (mode_chk_i = 0 at start) the 16 bits played out equal the remainder of x^16·d(x) modulo x^16+x^12+x^5+1. The register starts from all zeros and message bits are taken oldest first as the highest power: a one-bit message 1 gives 0x1021, and the ASCII string "123456789" gives 0x31C3.
- R3: The edge that takes the last message bit is followed by exactly 16 cycles with crc_valid_o = 1. These carry the remainder from bit 15 down to bit 0, and done_o rises in the cycle after the final remainder bit, with crc_valid_o back at 0.
- R4: In check mode (mode_chk_i = 1 at start), done_o rises one cycle after the edge that takes the last codeword bit. err_o is then 0 when the codeword equals a message followed by its correct remainder, and err_o is always 0 in generate mode.
- R5: In check mode, a codeword of up to 32767 bits is flagged with err_o = 1 when it carries any of these errors: a single-bit error, a double-bit error, a triple-bit error, any odd number of flipped bits, or one burst spanning 16 bits or fewer.
- R6: A cycle with bit_valid_i = 0 leaves the frame untouched. Inserting any number of idle cycles, with any values on bit_i and bit_last_i, does not change the result.
- R7: start_i clears the register, done_o, err_o and crc_valid_o on the next edge and wins over a simultaneous bit. Bits sent before a restart have no influence on the new frame.
- R8: The stage-XOR build (EXT_FORM = 0) and the single-feedback build (EXT_FORM = 1) give bit-identical serial output and flags for every input sequence.
- R9: Once the last bit has been taken, input strobes are ignored until the next start. This holds during the remainder playout and after done.
- R10: done_o and err_o hold their values until the next start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a frame: clears state, latches mode |
| mode_chk_i | input | 1 | 0 = generate, 1 = check; sampled with start_i |
| bit_valid_i | input | 1 | Qualifies bit_i and bit_last_i |
| bit_i | input | 1 | Serial frame bit, highest power first |
| bit_last_i | input | 1 | Marks the final bit of the frame |
| crc_bit_o | output | 1 | Serial remainder bit, MSB first |
| crc_valid_o | output | 1 | High while crc_bit_o carries a remainder bit |
| done_o | output | 1 | Frame finished; held until next start |
| err_o | output | 1 | Nonzero remainder in check mode; held until next start |

## Verification
The checker assumes that start_i is a single-cycle pulse issued between frames or as a deliberate abort. It also assumes every input is synchronous to clk. Under those conditions a remainder playout is never cut short except by start_i, and the flags change only at frame end or at start. The stimulus drives every input on the falling edge. It pulses start only between frames, or once on purpose in the middle of a frame. Codewords stay far below the 32767-bit limit on which the burst and low-weight detection guarantees rest.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int          CRC_W     = 16;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FIN   = 2'd3
  } crc_state_e;
endpackage

// File: rtl/crc_lfsr_int.sv
// Stage-XOR divider: the feedback bit fans out to every tap position.
module crc_lfsr_int #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] r_q;
  logic         fb;

  assign fb = din_i ^ r_q[W-1];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      r_q <= '0;
    end else if (en_i) begin
      r_q <= {r_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end
  end

  assign rem_o = r_q;
endmodule

// File: rtl/crc_lfsr_ext.sv
// Single-feedback divider: one XOR tree closes the loop, the chain holds
// the history of feedback bits, and the remainder is rebuilt from it.
module crc_lfsr_ext #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] rem_o
);
  // hist_q[j] is the feedback bit from j+1 enabled steps ago
  logic [W-1:0]          hist_q;
  logic [W-1:0]          tap_v;
  logic [W-1:0][W-1:0]   term_m;
  logic                  fb;

  for (genvar gi = 0; gi < W; gi++) begin : g_tap
    assign tap_v[gi] = POLY[gi] & hist_q[W-1-gi];
  end

  assign fb = din_i ^ (^tap_v);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      hist_q <= '0;
    end else if (en_i) begin
      hist_q <= {hist_q[W-2:0], fb};
    end
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_rem
    for (genvar gp = 0; gp < W; gp++) begin : g_term
      if (gp <= gi) begin : g_on
        assign term_m[gi][gp] = POLY[gp] & hist_q[gi-gp];
      end else begin : g_off
        assign term_m[gi][gp] = 1'b0;
      end
    end
    assign rem_o[gi] = ^term_m[gi];
  end
endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
  import crc16_pkg::*;
#(
  parameter int             WIDTH    = CRC_W,
  parameter logic [WIDTH-1:0] POLY   = CRC_POLY,
  parameter bit             EXT_FORM = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic mode_chk_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic bit_last_i,
  output logic crc_bit_o,
  output logic crc_valid_o,
  output logic done_o,
  output logic err_o
);
  localparam int                CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(WIDTH - 1);

  crc_state_e       state_q;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] rem;
  logic             take_bit;

  assign take_bit = (state_q == ST_RUN) && bit_valid_i && !start_i;

  if (EXT_FORM) begin : g_ext
    crc_lfsr_ext #(.W(WIDTH), .POLY(POLY)) lfsr_i (
      .clk(clk), .rst(rst), .clr_i(start_i),
      .en_i(take_bit), .din_i(bit_i), .rem_o(rem)
    );
  end else begin : g_int
    crc_lfsr_int #(.W(WIDTH), .POLY(POLY)) lfsr_i (
      .clk(clk), .rst(rst), .clr_i(start_i),
      .en_i(take_bit), .din_i(bit_i), .rem_o(rem)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= 1'b0;
      cnt_q       <= '0;
      crc_bit_o   <= 1'b0;
      crc_valid_o <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_RUN;
      mode_q      <= mode_chk_i;
      cnt_q       <= '0;
      crc_bit_o   <= 1'b0;
      crc_valid_o <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (bit_valid_i && bit_last_i) begin
            state_q <= mode_q ? ST_FIN : ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          crc_valid_o <= 1'b1;
          crc_bit_o   <= rem[LAST_IDX - cnt_q];
          if (cnt_q == LAST_IDX) begin
            state_q <= ST_FIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIN: begin
          crc_valid_o <= 1'b0;
          crc_bit_o   <= 1'b0;
          done_o      <= 1'b1;
          err_o       <= mode_q & (|rem);
          state_q     <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc16_serial_chk.sv
module crc16_serial_chk #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic crc_valid_o,
  input logic done_o,
  input logic err_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !crc_valid_o) run_q <= '0;
    else                     run_q <= run_q + 1'b1;
  end

  AST_RST_QUIET: assert property (@(posedge clk)
    $fell(rst) |-> !crc_valid_o && !done_o && !err_o); // R1

  AST_PLAY_BOUND: assert property (@(posedge clk) disable iff (rst)
    crc_valid_o |-> run_q < 8'(W)); // R3

  AST_PLAY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(crc_valid_o) && !$past(start_i) |-> run_q == 8'(W)); // R3

  AST_PLAY_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
    crc_valid_o |-> !done_o); // R3

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o); // R4

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !done_o && !err_o && !crc_valid_o); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o); // R10

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> $stable(err_o)); // R10
endmodule

bind crc16_serial crc16_serial_chk #(.W(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i),
  .crc_valid_o(crc_valid_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/crc16_serial_tb_top.sv
`timescale 1ns/1ps
module crc16_serial_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode_chk = 1'b0, vld = 1'b0, bit_in = 1'b0, last = 1'b0;
  logic cb_a, cv_a, dn_a, er_a;
  logic cb_b, cv_b, dn_b, er_b;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic tx_q [0:1023];

  always #4 clk = ~clk;

  crc16_serial #(.EXT_FORM(1'b0)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .mode_chk_i(mode_chk),
    .bit_valid_i(vld), .bit_i(bit_in), .bit_last_i(last),
    .crc_bit_o(cb_a), .crc_valid_o(cv_a), .done_o(dn_a), .err_o(er_a));

  crc16_serial #(.EXT_FORM(1'b1)) dut_ext_i (
    .clk(clk), .rst(rst), .start_i(start), .mode_chk_i(mode_chk),
    .bit_valid_i(vld), .bit_i(bit_in), .bit_last_i(last),
    .crc_bit_o(cb_b), .crc_valid_o(cv_b), .done_o(dn_b), .err_o(er_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Long division of the zero-augmented message
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n + 16; i++) begin
      logic b  = (i < n) ? tx_q[i] : 1'b0;
      logic hi = r[15];
      r = {r[14:0], b};
      if (hi) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic begin_frame(input logic chk_mode);
    @(negedge clk); start = 1'b1; mode_chk = chk_mode; vld = 1'b0; last = 1'b0;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_frame(input int n, input int gap_pct, input bit use_last);
    for (int i = 0; i < n; i++) begin
      while (int'($urandom % 100) < gap_pct) begin
        vld = 1'b0; bit_in = 1'($urandom); last = 1'($urandom);
        @(negedge clk);
      end
      vld = 1'b1; bit_in = tx_q[i]; last = use_last && (i == n - 1);
      @(negedge clk);
    end
    vld = 1'b0; last = 1'b0;
  endtask

  task automatic run_gen(input int n, input int gap_pct, input bit noise,
                         output logic [15:0] got);
    logic [15:0] ca = '0, cb = '0, exp;
    exp = ref_crc(n);
    begin_frame(1'b0);
    send_frame(n, gap_pct, 1'b1);
    for (int k = 0; k < 16; k++) begin
      if (noise) begin vld = 1'($urandom); bit_in = 1'($urandom); last = 1'($urandom); end
      @(negedge clk);
      ca = {ca[14:0], cb_a};
      cb = {cb[14:0], cb_b};
      if (!(cv_a && cv_b && !dn_a)) chk(1'b0, "R3 playout valid", {cv_a, cv_b, dn_a}, 3'b110);
    end
    vld = 1'b0; last = 1'b0;
    @(negedge clk);
    chk(dn_a && !cv_a && dn_b && !cv_b && !er_a, "R3/R4 done after playout",
        {dn_a, cv_a, dn_b, cv_b, er_a}, 5'b10100);
    chk(ca == exp, "R2 remainder", ca, exp);
    chk(cb == ca, "R8 forms agree", cb, ca);
    got = ca;
  endtask

  task automatic run_check(input int n, input int gap_pct, input logic exp_err,
                           input string req);
    begin_frame(1'b1);
    send_frame(n, gap_pct, 1'b1);
    @(negedge clk);
    chk(dn_a && er_a == exp_err, req, {dn_a, er_a}, {1'b1, exp_err});
    chk(dn_b == dn_a && er_b == er_a, "R8 forms agree on check", {dn_b, er_b}, {dn_a, er_a});
  endtask

  task automatic flip(input int p);
    tx_q[p] = ~tx_q[p];
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=frame_end");
      finish_run();
    end
  end

  initial begin
    logic [15:0] crc;
    string s;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk({cb_a, cv_a, dn_a, er_a} == 4'b0, "R1 in reset", {cb_a, cv_a, dn_a, er_a}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({cb_a, cv_a, dn_a, er_a, cv_b, dn_b} == 6'b0, "R1 after reset",
        {cb_a, cv_a, dn_a, er_a, cv_b, dn_b}, 0);

    // R9: idle strobes before any frame are ignored
    for (int i = 0; i < 6; i++) begin
      vld = 1'b1; bit_in = 1'($urandom); last = 1'b1; @(negedge clk);
    end
    vld = 1'b0; last = 1'b0;
    chk(!dn_a && !cv_a && !er_a, "R9 no frame without start", {dn_a, cv_a, er_a}, 0);

    // Directed remainders
    tx_q[0] = 1'b1;
    run_gen(1, 0, 1'b0, crc);
    chk(crc == 16'h1021, "R2 single one", crc, 16'h1021);

    s = "123456789";
    for (int c = 0; c < 9; c++)
      for (int b = 0; b < 8; b++) tx_q[8*c+b] = s[c][7-b];
    run_gen(72, 30, 1'b1, crc);
    chk(crc == 16'h31C3, "R2 ascii string", crc, 16'h31C3);

    for (int i = 0; i < 40; i++) tx_q[i] = 1'b0;
    run_gen(40, 0, 1'b0, crc);
    chk(crc == 16'h0000, "R2 zero message", crc, 0);
    for (int i = 0; i < 16; i++) tx_q[40+i] = 1'b0;
    run_check(56, 0, 1'b0, "R4 zero codeword clean");

    // R10 + R9: flags hold, strobes after done ignored
    for (int i = 0; i < 6; i++) begin
      vld = 1'($urandom); bit_in = 1'($urandom); last = 1'($urandom); @(negedge clk);
      chk(dn_a && !er_a && !cv_a, "R10/R9 hold after done", {dn_a, er_a, cv_a}, 3'b100);
    end
    vld = 1'b0; last = 1'b0;

    // R7: abort a frame, restart with a clean message
    begin_frame(1'b0);
    for (int i = 0; i < 12; i++) tx_q[i] = 1'($urandom);
    send_frame(12, 0, 1'b0);
    for (int i = 0; i < 30; i++) tx_q[i] = 1'($urandom);
    run_gen(30, 10, 1'b0, crc);
    chk(crc == ref_crc(30), "R7 restart discards old bits", crc, ref_crc(30));

    // R7: start wins over a bit in the same cycle
    @(negedge clk); start = 1'b1; mode_chk = 1'b1; vld = 1'b1; bit_in = 1'b1; last = 1'b1;
    @(negedge clk); start = 1'b0; vld = 1'b0; last = 1'b0;
    @(negedge clk);
    chk(!dn_a && !er_a, "R7 start beats bit", {dn_a, er_a}, 0);
    for (int i = 0; i < 20; i++) tx_q[i] = 1'b0;
    send_frame(20, 0, 1'b1);
    @(negedge clk);
    chk(dn_a && !er_a, "R7 no residue from dropped bit", {dn_a, er_a}, 2'b10);

    // Random frames with gaps, playout noise and error injection
    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom % 96);
      int total = n + 16;
      int gap = int'($urandom % 40);
      for (int i = 0; i < n; i++) tx_q[i] = 1'($urandom);
      run_gen(n, gap, t[0], crc);
      for (int i = 0; i < 16; i++) tx_q[n+i] = crc[15-i];
      run_check(total, gap, 1'b0, "R4/R6 clean codeword");
      case (t % 5)
        0: flip(int'($urandom % total));
        1: begin
          int p1 = int'($urandom % (total - 1));
          int p2 = p1 + 1 + int'($urandom % (total - 1 - p1));
          flip(p1); flip(p2);
        end
        2: begin
          int p1 = int'($urandom % (total - 2));
          int p2 = p1 + 1 + int'($urandom % (total - 2 - p1));
          int p3 = p2 + 1 + int'($urandom % (total - 1 - p2));
          flip(p1); flip(p2); flip(p3);
        end
        3: begin
          int p = int'($urandom % (total - 12));
          for (int w = 0; w < 5; w++) begin
            flip(p);
            p = p + 1 + int'($urandom % 3);
          end
        end
        default: begin
          int len = 1 + int'($urandom % 16);
          int p = int'($urandom % (total - len + 1));
          flip(p);
          if (len > 1) flip(p + len - 1);
          for (int i = p + 1; i < p + len - 1; i++) if ($urandom % 2) flip(i);
        end
      endcase
      run_check(total, gap, 1'b1, "R5 corrupted codeword detected");
    end

    finished = 1'b1;
    finish_run();
  end
endmodule